// File: doc/BRIEF.md
# Direct-Mapped Write-Through Word Cache

This block is a small cache that sits between a processor-side port and a main-memory port. It holds 1024 lines, and each line keeps a valid flag, a 20-bit tag and one 32-bit data word. The line is chosen by the index bits of the byte address, and a lookup hits when the line is valid and its tag matches the address. A read hit returns data in the same cycle as the request.

A read miss holds the requester off. The block then fetches the word from memory, places it in the line, and serves the still-held request from the line on the following cycle. Every write updates the line at once, with no prior hit check and no fetch, because a block is a single word. The write is then forwarded to memory, and the requester is released in the cycle that memory acknowledges it.

The memory port uses a plain request/acknowledge exchange and tolerates any latency. The requester must hold its request and operands steady until `cpu_ready` is seen high. It may present a new access in the next cycle.

Top module: `wt_dm_cache`

## Requirements
- R1: After reset every line is invalid, so the first read of any address misses (`cpu_hit` low) and causes a memory read.
- R2: Address bits 11..2 select the line and bits 31..12 form the tag. Two addresses with the same index and different tags evict each other, and addresses with different indices do not share a line.
- R3: A read that hits raises `cpu_hit` and `cpu_ready` and presents the stored word on `cpu_rdata` in the same cycle as the request, with no memory request.
- R4: On a read miss `cpu_ready` stays low. `mem_req` is raised with `mem_we` low and `mem_addr` equal to the request address with bits 1..0 cleared, and it is held until `mem_ack`. With memory acknowledging L cycles after its first sampled request, the read completes L+2 cycles after it is presented.
- R5: The word on `mem_rdata` in the acknowledge cycle is written into the line, and the held read then completes with that word.
- R6: A write is accepted in the cycle it is presented. The line takes the new tag and data and becomes valid. `mem_req` and `mem_we` are then raised with the word-aligned address and the write data, and `cpu_ready` is high only in the `mem_ack` cycle, L+1 cycles after the write is presented.
- R7: A write that misses causes no memory read, and a later read of that address hits and returns the written word.
- R8: The request's byte offset (bits 1..0) has no effect on lookup, line selection or the memory address.
- R9: While `mem_req` is high and `mem_ack` is low, the memory request, address and direction stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data from the selected line |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_hit | output | 1 | Lookup hit for the presented request |
| mem_req | output | 1 | Memory transaction outstanding |
| mem_we | output | 1 | Memory transaction is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory completes the transaction |

## Verification
The hardest case to reach is the fill handoff. The acknowledge edge writes the line and returns control to the idle state, and the same held read must then complete from the array on the next cycle. A second case is a conflicting tag that evicts a line which was just filled. The bench uses a memory responder with programmable latency, including zero, and replays reads of the same index with different tags and offsets. It checks the exact completion cycle and counts the memory reads, so that both a missing fill and a spurious fetch are exposed.

// File: rtl/wt_dm_cache.sv
`timescale 1ns/1ps
module wt_dm_cache #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 10,
  parameter int OFF_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  output logic          cpu_hit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int TAG_W = AW - IDX_W - OFF_W;
  localparam int LINES = 1 << IDX_W;
  localparam int LW    = AW - OFF_W;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WRITE} st_t;
  st_t st;

  logic [LINES-1:0] vld;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES];
  logic [LW-1:0]    lat_line;
  logic [DW-1:0]    lat_data;

  wire unused_off = ^cpu_addr[OFF_W-1:0];

  wire [IDX_W-1:0] idx     = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag     = cpu_addr[AW-1 -: TAG_W];
  wire [IDX_W-1:0] lat_idx = lat_line[IDX_W-1:0];
  wire [TAG_W-1:0] lat_tag = lat_line[LW-1 -: TAG_W];
  wire             match   = vld[idx] && (tag_q[idx] == tag);
  wire             idle    = (st == S_IDLE);
  wire             acc_wr  = idle && cpu_req && cpu_we;
  wire             acc_rd  = idle && cpu_req && !cpu_we;

  assign cpu_hit   = idle && cpu_req && match;
  assign cpu_rdata = data_q[idx];
  assign cpu_ready = (acc_rd && match) || (st == S_WRITE && mem_ack);
  assign mem_req   = !idle;
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = {lat_line, {OFF_W{1'b0}}};
  assign mem_wdata = lat_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      vld <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (acc_wr) begin
            vld[idx] <= 1'b1;
            st       <= S_WRITE;
          end else if (acc_rd && !match) begin
            st <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          vld[lat_idx] <= 1'b1;
          st           <= S_IDLE;
        end
        S_WRITE: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (idle && cpu_req) begin
      lat_line <= cpu_addr[AW-1:OFF_W];
      lat_data <= cpu_wdata;
    end
    if (acc_wr) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= cpu_wdata;
    end else if (st == S_FILL && mem_ack) begin
      tag_q[lat_idx]  <= lat_tag;
      data_q[lat_idx] <= mem_rdata;
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (vld == '0));
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && !cpu_we) |-> (cpu_hit && !mem_req));
  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !cpu_hit && !mem_req) |=> (mem_req && !mem_we && !cpu_ready));
  p_fill_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> vld[lat_idx]);
  p_write_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !mem_req) |=> (mem_req && mem_we));
  p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/wt_dm_cache_tb_top.sv
`timescale 1ns/1ps
module wt_dm_cache_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready, cpu_hit;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic        mem_ack = 0;

  int checks = 0, errors = 0;
  int lat = 2, cnt = 0, rd_acks = 0, wr_acks = 0;
  logic [31:0] last_addr = 0, last_wdata = 0;
  logic        last_we = 0;

  always #2.5 clk = ~clk;

  wt_dm_cache dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  initial forever begin
    @(negedge clk);
    if (mem_ack) begin
      mem_ack = 0;
      cnt = 0;
    end else if (mem_req) begin
      cnt++;
      if (cnt > lat) begin
        mem_ack = 1;
        last_addr = mem_addr;
        last_we = mem_we;
        last_wdata = mem_wdata;
        if (mem_we) wr_acks++;
        else begin
          rd_acks++;
          mem_rdata = pat(mem_addr);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output logic hit0, output int cyc);
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    hit0 = cpu_hit;
    cyc = 0;
    while (!cpu_ready && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
  endtask

  logic [31:0] rd;
  logic        h;
  int          cyc, r0, w0;

  task automatic t_reset;
    @(negedge clk); #1;
    chk("R1 idle ready", {31'b0, cpu_ready}, 0);
    chk("R1 idle mem_req", {31'b0, mem_req}, 0);
    r0 = rd_acks;
    lat = 1;
    access(0, 32'h0000_0100, 0, rd, h, cyc);
    chk("R1 first read misses", {31'b0, h}, 0);
    chk("R1 memory read issued", rd_acks, r0 + 1);
  endtask

  task automatic t_miss_fill;
    lat = 3; r0 = rd_acks;
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R4 miss flag", {31'b0, h}, 0);
    chk("R4 miss completion cycle", cyc, lat + 2);
    chk("R4 mem address aligned", last_addr, 32'h0000_1234);
    chk("R4 mem direction read", {31'b0, last_we}, 0);
    chk("R5 filled word", rd, pat(32'h0000_1234));
    chk("R5 one fetch", rd_acks, r0 + 1);
  endtask

  task automatic t_hit;
    r0 = rd_acks;
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R3 hit flag", {31'b0, h}, 1);
    chk("R3 same-cycle completion", cyc, 0);
    chk("R3 hit data", rd, pat(32'h0000_1234));
    chk("R3 no memory access", rd_acks, r0);
  endtask

  task automatic t_offset;
    r0 = rd_acks;
    access(0, 32'h0000_1237, 0, rd, h, cyc);
    chk("R8 offset ignored hit", {31'b0, h}, 1);
    chk("R8 offset ignored data", rd, pat(32'h0000_1234));
    lat = 0;
    access(0, 32'h0000_5556, 0, rd, h, cyc);
    chk("R8 miss address aligned", last_addr, 32'h0000_5554);
    chk("R8 fill data", rd, pat(32'h0000_5554));
  endtask

  task automatic t_conflict;
    lat = 1; r0 = rd_acks;
    access(0, 32'h0000_2234, 0, rd, h, cyc);
    chk("R2 tag conflict misses", {31'b0, h}, 0);
    chk("R2 conflict data", rd, pat(32'h0000_2234));
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R2 evicted line misses", {31'b0, h}, 0);
    access(0, 32'h0000_2238, 0, rd, h, cyc);
    chk("R2 other index misses", {31'b0, h}, 0);
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R2 neighbour index kept line", {31'b0, h}, 1);
    chk("R2 fetch count", rd_acks, r0 + 3);
  endtask

  task automatic t_write_miss;
    lat = 2; r0 = rd_acks; w0 = wr_acks;
    access(1, 32'h0004_0013, 32'hDEAD_BEEF, rd, h, cyc);
    chk("R6 write completion cycle", cyc, lat + 1);
    chk("R6 write address", last_addr, 32'h0004_0010);
    chk("R6 write data", last_wdata, 32'hDEAD_BEEF);
    chk("R6 write direction", {31'b0, last_we}, 1);
    chk("R7 no fetch on write miss", rd_acks, r0);
    access(0, 32'h0004_0010, 0, rd, h, cyc);
    chk("R7 read after write hits", {31'b0, h}, 1);
    chk("R7 written word", rd, 32'hDEAD_BEEF);
    chk("R6 one memory write", wr_acks, w0 + 1);
  endtask

  task automatic t_write_hit;
    lat = 0;
    access(1, 32'h0000_1234, 32'h0123_4567, rd, h, cyc);
    chk("R6 write zero latency cycle", cyc, 1);
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R6 overwritten word", rd, 32'h0123_4567);
    access(1, 32'h0000_3234, 32'hCAFE_F00D, rd, h, cyc);
    access(0, 32'h0000_3234, 0, rd, h, cyc);
    chk("R6 write retags line", {31'b0, h}, 1);
    access(0, 32'h0000_1234, 0, rd, h, cyc);
    chk("R2 old tag replaced", {31'b0, h}, 0);
  endtask

  task automatic t_latency;
    lat = 7;
    access(0, 32'h00AB_C000, 0, rd, h, cyc);
    chk("R9 long latency cycle", cyc, 9);
    chk("R9 long latency data", rd, pat(32'h00AB_C000));
    chk("R9 held address", last_addr, 32'h00AB_C000);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_miss_fill;
    t_hit;
    t_offset;
    t_conflict;
    t_write_miss;
    t_write_hit;
    t_latency;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule